// File: doc/BRIEF.md
# Converter Supply Start-up and Fault Supervisor

This block supervises the supply and the fault state of a switching converter controller. It takes digitized comparator flags: two supply lockout levels, two top-up charge levels, over-current, over-voltage, two temperature levels and a reference-good flag. From these it drives the enable of the high-voltage start-up charger, the internal regulator enable, the core reset and the driver enable that gates the switching sequencer. It also gates the bleeder request so that the bleeder and the charger are never active together.

At power-up the block holds the converter in lockout with the charger running. When the supply rises above the upper lockout level, it turns the charger off and enables the regulator first. It releases the core reset and the driver once the reference reports good. In normal operation the charger tops up the supply with hysteresis. Over-current and over-voltage faults latch. They are cleared only when the supply has stayed below the lockout-off level without interruption for a hold time that is derived from the clock frequency. The thermal fault releases by itself when the cool-level flag is seen. Each comparator flag passes through a two-flop synchronizer before use.

Top module: `supply_supervisor`

## Requirements
- R1: After reset the block is in lockout: charger_en=1, reg_en=0, core_reset=1, drv_en=0.
- R2: When the flag sup_above_on_i is seen (and sup_below_off_i is low), the block leaves lockout. reg_en becomes 1 and core_reset stays 1, and charger_en drops to 0 if no top-up is pending.
- R3: core_reset falls, and drv_en becomes 1 when no fault is present, only once ref_good_i is 1 after regulator enable. While ref_good_i is 0, core_reset stays 1.
- R4: sup_below_off_i=1 returns the block to lockout from any state, with the outputs of R1.
- R5: Outside lockout, charger_en rises when sup_low_i=1, stays 1 while neither flag is set, and falls when sup_high_i=1.
- R6: An over-current flag latches a fault that forces drv_en=0 only when blank_done_i=1 at the same time. While blank_done_i=0 the flag is ignored.
- R7: An over-voltage flag latches a fault that forces drv_en=0. The fault persists after the flag goes away.
- R8: The latched faults clear only after sup_below_off_i has been 1 for HOLD_US microseconds without a break. Any break restarts the count, and the faults survive a lockout that is shorter than the hold time.
- R9: temp_hot_i=1 forces drv_en=0. Driving is restored without lockout once temp_cool_i=1, and it stays off while neither flag is set.
- R10: bleed_en follows bleed_req_i while charger_en=0 and is forced to 0 while charger_en=1.
- R11: Every flag input passes through two flops, so no output changes at the first clock edge after a flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sup_above_on_i | input | 1 | supply above upper lockout level |
| sup_below_off_i | input | 1 | supply below lower lockout level |
| sup_low_i | input | 1 | supply below top-up start level |
| sup_high_i | input | 1 | supply above top-up stop level |
| ocp_i | input | 1 | current sense at over-current level |
| blank_done_i | input | 1 | leading-edge blank window over (synchronous) |
| ovp_i | input | 1 | supply above over-voltage level |
| temp_hot_i | input | 1 | temperature above shutdown level |
| temp_cool_i | input | 1 | temperature below release level |
| ref_good_i | input | 1 | internal reference in regulation |
| bleed_req_i | input | 1 | bleeder current requested |
| charger_en | output | 1 | start-up/top-up charger enable |
| bleed_en | output | 1 | bleeder enable |
| reg_en | output | 1 | internal regulator enable |
| core_reset | output | 1 | core reset, active high |
| drv_en | output | 1 | switching driver enable |

## Verification
A wrong sequencer state shows at the ports within three clock edges of a flag change, as a mismatched reg_en, core_reset or charger_en pattern. A wrong fault latch shows at drv_en once the block is back in run. A wrong hold counter appears only at the end of a lockout. For that reason the bench returns to run just before and just after the hold time, and after an interrupted lockout, and then reads drv_en. A wrong top-up state shows on charger_en only in the band between the two top-up levels, so that band is checked on its own.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {ST_LOCK = 2'd0, ST_REGUP = 2'd1, ST_RUN = 2'd2} supv_state_t;

  // cycles of clk in a hold window of hold_us microseconds
  function automatic longint hold_cycles(longint clk_hz, longint hold_us);
    return (clk_hz * hold_us) / 64'd1000000;
  endfunction
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/supv_seq.sv
module supv_seq
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic above_on_s,
  input  logic below_off_s,
  input  logic low_s,
  input  logic high_s,
  input  logic ref_s,
  output logic charger_en,
  output logic reg_en,
  output logic core_reset,
  output logic run_o
);
  supv_state_t st_q, st_d;
  logic topup_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCK:  if (above_on_s) st_d = ST_REGUP;
      ST_REGUP: if (ref_s)      st_d = ST_RUN;
      ST_RUN:   st_d = ST_RUN;
      default:  st_d = ST_LOCK;
    endcase
    if (below_off_s) st_d = ST_LOCK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LOCK;
      topup_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LOCK)  topup_q <= 1'b0;
      else if (low_s)       topup_q <= 1'b1;
      else if (high_s)      topup_q <= 1'b0;
    end
  end

  assign charger_en = (st_q == ST_LOCK) | topup_q;
  assign reg_en     = (st_q != ST_LOCK);
  assign core_reset = (st_q != ST_RUN);
  assign run_o      = (st_q == ST_RUN);

  a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> ($past(st_q) != ST_LOCK));
  a_r3_ref_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> $past(ref_s));
  a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
    below_off_s |=> (st_q == ST_LOCK));
  a_r5_topup_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(topup_q) |-> $past(low_s));
endmodule

// File: rtl/supv_faults.sv
module supv_faults
  import supv_pkg::*;
#(
  parameter longint CLK_HZ  = 125_000_000,
  parameter longint HOLD_US = 10_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_off_s,
  input  logic ocp_s,
  input  logic blank_done_i,
  input  logic ovp_s,
  input  logic hot_s,
  input  logic cool_s,
  output logic fault_o,
  output logic clr_evt_o
);
  localparam int HOLD_CYC = int'(hold_cycles(CLK_HZ, HOLD_US));
  localparam int CW       = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic ocp_lat_q, ovp_lat_q, ot_q;

  assign clr_evt_o = below_off_s && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ocp_lat_q <= 1'b0;
      ovp_lat_q <= 1'b0;
      ot_q      <= 1'b0;
    end else begin
      if (!below_off_s)    cnt_q <= '0;
      else if (!clr_evt_o) cnt_q <= cnt_q + 1'b1;
      if (clr_evt_o)                  ocp_lat_q <= 1'b0;
      else if (ocp_s && blank_done_i) ocp_lat_q <= 1'b1;
      if (clr_evt_o)  ovp_lat_q <= 1'b0;
      else if (ovp_s) ovp_lat_q <= 1'b1;
      if (hot_s)       ot_q <= 1'b1;
      else if (cool_s) ot_q <= 1'b0;
    end
  end

  assign fault_o = ocp_lat_q | ovp_lat_q | ot_q;

  a_r6_ocp_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_lat_q) |-> $past(ocp_s && blank_done_i));
  a_r8_clear_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ocp_lat_q) || $fell(ovp_lat_q)) |-> $past(below_off_s));
  a_r9_ot_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_q) |-> $past(cool_s && !hot_s));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter longint CLK_HZ  = 125_000_000,
  parameter longint HOLD_US = 10_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on_i,
  input  logic sup_below_off_i,
  input  logic sup_low_i,
  input  logic sup_high_i,
  input  logic ocp_i,
  input  logic blank_done_i,
  input  logic ovp_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic ref_good_i,
  input  logic bleed_req_i,
  output logic charger_en,
  output logic bleed_en,
  output logic reg_en,
  output logic core_reset,
  output logic drv_en
);
  localparam int NF = 10;
  logic [NF-1:0] raw, syn;
  logic run, fault, clr_evt;

  assign raw = {bleed_req_i, ref_good_i, temp_cool_i, temp_hot_i, ovp_i,
                ocp_i, sup_high_i, sup_low_i, sup_below_off_i, sup_above_on_i};

  supv_sync2 #(.W(NF)) sync_i (.clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  supv_seq seq_i (
    .clk(clk), .rst_n(rst_n),
    .above_on_s(syn[0]), .below_off_s(syn[1]), .low_s(syn[2]), .high_s(syn[3]),
    .ref_s(syn[8]),
    .charger_en(charger_en), .reg_en(reg_en), .core_reset(core_reset), .run_o(run)
  );

  supv_faults #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) flt_i (
    .clk(clk), .rst_n(rst_n),
    .below_off_s(syn[1]), .ocp_s(syn[4]), .blank_done_i(blank_done_i),
    .ovp_s(syn[5]), .hot_s(syn[6]), .cool_s(syn[7]),
    .fault_o(fault), .clr_evt_o(clr_evt)
  );

  assign drv_en   = run & ~fault;
  assign bleed_en = syn[9] & ~charger_en;

  a_r1_lock_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (charger_en && core_reset && !drv_en));
  a_r7_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !drv_en);
  a_r10_bleed_excl: assert property (@(posedge clk) disable iff (!rst_n)
    bleed_en |-> !charger_en);
  a_r8_clear_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> !reg_en);
endmodule

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  localparam int HOLD = 1000; // 1 MHz nominal x 1000 us
  logic clk = 1'b0, rst_n = 1'b0;
  logic above_on = 0, below_off = 0, s_low = 0, s_high = 0, ocp = 0, blank = 0;
  logic ovp = 0, hot = 0, cool = 0, refg = 0, bleed = 0;
  logic charger_en, bleed_en, reg_en, core_reset, drv_en;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  supply_supervisor #(.CLK_HZ(1_000_000), .HOLD_US(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_above_on_i(above_on), .sup_below_off_i(below_off),
    .sup_low_i(s_low), .sup_high_i(s_high), .ocp_i(ocp), .blank_done_i(blank),
    .ovp_i(ovp), .temp_hot_i(hot), .temp_cool_i(cool), .ref_good_i(refg),
    .bleed_req_i(bleed), .charger_en(charger_en), .bleed_en(bleed_en),
    .reg_en(reg_en), .core_reset(core_reset), .drv_en(drv_en));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_run();
    below_off = 0; above_on = 1; s_high = 1; s_low = 0; refg = 1;
    waitn(6);
  endtask

  task automatic go_lock();
    above_on = 0; refg = 0; below_off = 1;
    waitn(6);
  endtask

  task automatic t_reset();
    chk("R1 charger_en", charger_en, 1); chk("R1 reg_en", reg_en, 0);
    chk("R1 core_reset", core_reset, 1); chk("R1 drv_en", drv_en, 0);
  endtask

  task automatic t_startup();
    s_high = 1; above_on = 1; waitn(6);
    chk("R2 reg_en", reg_en, 1); chk("R2 charger off", charger_en, 0);
    chk("R3 reset held w/o ref", core_reset, 1); chk("R3 drv off", drv_en, 0);
    refg = 1; waitn(6);
    chk("R3 reset released", core_reset, 0); chk("R3 drv on", drv_en, 1);
  endtask

  task automatic t_sync();
    @(negedge clk); below_off = 1; above_on = 0;
    @(negedge clk);
    chk("R11 no change after one edge", reg_en, 1);
    waitn(5);
    chk("R4 reg_en off", reg_en, 0); chk("R4 charger on", charger_en, 1);
    chk("R4 reset", core_reset, 1); chk("R4 drv off", drv_en, 0);
    waitn(HOLD + 20);
    go_run();
  endtask

  task automatic t_topup();
    s_high = 0; waitn(6);
    chk("R5 off in band", charger_en, 0);
    s_low = 1; waitn(6);
    chk("R5 on below low", charger_en, 1);
    s_low = 0; waitn(6);
    chk("R5 held in band", charger_en, 1);
    chk("R10 bleed blocked while charging", bleed_en, 0);
    s_high = 1; waitn(6);
    chk("R5 off above high", charger_en, 0);
  endtask

  task automatic t_bleed();
    bleed = 1; waitn(4);
    chk("R10 bleed follows", bleed_en, 1);
    bleed = 0; waitn(4);
    chk("R10 bleed off", bleed_en, 0);
  endtask

  task automatic t_ocp();
    blank = 0; ocp = 1; waitn(6); ocp = 0; waitn(4);
    chk("R6 ocp ignored in blank", drv_en, 1);
    ocp = 1; waitn(2); blank = 1; waitn(3); blank = 0; ocp = 0; waitn(4);
    chk("R6 ocp latched", drv_en, 0);
    go_lock(); waitn(HOLD - 30); go_run();
    chk("R8 short lockout keeps fault", drv_en, 0);
    go_lock(); waitn(HOLD + 20); go_run();
    chk("R8 full hold clears ocp", drv_en, 1);
  endtask

  task automatic t_ovp();
    ovp = 1; waitn(5); ovp = 0; waitn(10);
    chk("R7 ovp latched", drv_en, 0);
    go_lock(); waitn(600);
    below_off = 0; waitn(20); below_off = 1;
    waitn(600); go_run();
    chk("R8 interrupted hold restarts", drv_en, 0);
    go_lock(); waitn(HOLD + 20); go_run();
    chk("R8 clears ovp", drv_en, 1);
  endtask

  task automatic t_thermal();
    hot = 1; waitn(5); hot = 0; waitn(10);
    chk("R9 hot stops", drv_en, 0);
    chk("R9 no lockout", reg_en, 1);
    cool = 1; waitn(5); cool = 0; waitn(3);
    chk("R9 auto release", drv_en, 1);
  endtask

  initial begin
    waitn(3); rst_n = 1; waitn(2);
    t_reset(); t_startup(); t_sync(); t_topup(); t_bleed();
    t_ocp(); t_ovp(); t_thermal();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule